// File: doc/BRIEF.md
# Page Map and Storage Initialization Sequencer

This block brings a paged memory system into a known state after power-up or a restart. On a start request it takes a snapshot of the storage configuration: which of four storage modules are fitted, the chip-size code that sets how many pages each module holds, and two indicators that select how large the virtual map is. It then drives a map-write port and a memory request port to build the virtual-to-real page table. The real pages of all fitted modules are packed into one unbroken run of virtual pages. On a cold start it also clears every mapped page to zero.

A cold start first points every virtual page at the real page with the same number. It then flushes each page from the cache and marks the page vacant. Last, it maps the fitted storage, starting at a chosen base bank and wrapping past the top of virtual space, and zeroes each page right after mapping it. A warm start skips the identity pass and the zeroing, so storage contents survive. It still flushes, vacates and remaps. An optional last step flushes the final page of the base bank and write-protects its map entry. The block reports the virtual size in banks, the total real page count and a one-cycle done pulse. If no module is fitted, it raises a no-storage flag and does nothing else.

A page holds 2^PAGE_LOG words and a bank holds 2^BANK_LOG pages. The defaults are 256 words per page and 256 pages per bank, which gives 64K-word banks.

Top module: `map_init_seq`

## Requirements
- R1: `vbanks` equals 1024 when `map_large` is 1, otherwise 256 when `map_medium` is 1, otherwise 64. Both indicators are sampled with `start`.
- R2: Pages per module is PPM_BASE shifted left by twice `chip_code`. `real_pages` equals the number of 1 bits in `mod_present` times pages per module. It is loaded at `start` and holds steady until the next accepted start.
- R3: On a cold start (`warm`=0) the first pass writes every virtual page from 0 upward. Each entry is {dirty=0, wp=0, real page = virtual page mod 2^RPN_W}. `map_entry` is laid out as bit ENT_W-1 = dirty, bit ENT_W-2 = write-protect, and the low RPN_W bits = real page.
- R4: On both paths, each virtual page from 0 upward gets 2^MUNCH_LOG flush requests (`mem_zero`=0). The word offsets are m*2^(PAGE_LOG-MUNCH_LOG), with m ascending. The page's entry is then written vacant as {1,1,0}.
- R5: The mapping pass visits modules 0 to 3 in order. An absent module adds one module's page count to the real page counter (which starts at 0) and writes nothing. A present module maps each of its real pages in turn to the next virtual page with entry {0,0,real page}.
- R6: Mapping starts at virtual page (`base_bank` AND (`vbanks`-1)) * 2^BANK_LOG. After the last virtual page it continues at virtual page 0.
- R7: On a cold start, right after each mapping write, the block issues zero stores (`mem_zero`=1) to all words of that page, in ascending offset order. On a warm start it issues no zero store at all.
- R8: A start with `mod_present`=0 sets `nostore` and produces no map write, no memory request and no done pulse. The next start with storage present clears `nostore`.
- R9: With `protect_top`=1, after mapping, the last virtual page of the selected base bank gets the same munch flushes as in R4. Its entry is then written {0,1,rp}, where rp is the real page mapped there in this run (or 0 if none).
- R10: `map_we` is never high while `map_busy` is high. After each map write the block issues nothing until `map_busy` is low again. The port must raise `map_busy` no later than one cycle after the write if it needs time.
- R11: `mem_req` stays high with `mem_addr` and `mem_zero` unchanged until a cycle in which `mem_ack` is high.
- R12: `done` is high for exactly one cycle after the last operation of a run with storage present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted when idle |
| warm | input | 1 | 1 selects warm start, 0 cold start |
| mod_present | input | 4 | Fitted storage modules, bit i = module i |
| chip_code | input | 2 | Storage chip-size code |
| map_large | input | 1 | Largest map size indicator |
| map_medium | input | 1 | Medium map size indicator |
| protect_top | input | 1 | Enable final write-protect step |
| base_bank | input | BASE_W | Bank where mapping begins |
| map_busy | input | 1 | Map port busy |
| map_we | output | 1 | Map entry write strobe |
| map_vpage | output | 10+BANK_LOG | Virtual page of the entry written |
| map_entry | output | RPN_W+2 | {dirty, write-protect, real page} |
| mem_req | output | 1 | Memory request |
| mem_zero | output | 1 | 1 = store zero, 0 = cache flush |
| mem_addr | output | 10+BANK_LOG+PAGE_LOG | Word address {virtual page, offset} |
| mem_ack | input | 1 | Memory request accepted |
| done | output | 1 | One-cycle completion pulse |
| nostore | output | 1 | No storage module present |
| vbanks | output | 11 | Virtual size in banks |
| real_pages | output | $clog2(PPM_BASE)+9 | Total real pages |

## Verification
Any fault in the page, module or word counters shows up at the ports within one map write or memory request. Such a fault changes the virtual page, the entry or the address of the very next operation. A wrong wrap point or base bank shows up on the first mapping write past the boundary. A wrong path choice between cold and warm shows up as the first operation, or as a zero store appearing (or missing) one cycle after a mapping write settles. Handshake faults show up in the same cycle as a write under busy, or as a request that moves before it is acknowledged.

// File: rtl/map_init_seq.sv
module map_init_seq #(
  parameter int PAGE_LOG  = 8,
  parameter int BANK_LOG  = 8,
  parameter int MUNCH_LOG = 4,
  parameter int PPM_BASE  = 256,
  parameter int RPN_W     = 16,
  parameter int BASE_W    = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 warm,
  input  logic [3:0]                           mod_present,
  input  logic [1:0]                           chip_code,
  input  logic                                 map_large,
  input  logic                                 map_medium,
  input  logic                                 protect_top,
  input  logic [BASE_W-1:0]                    base_bank,
  input  logic                                 map_busy,
  output logic                                 map_we,
  output logic [10+BANK_LOG-1:0]               map_vpage,
  output logic [RPN_W+1:0]                     map_entry,
  output logic                                 mem_req,
  output logic                                 mem_zero,
  output logic [10+BANK_LOG+PAGE_LOG-1:0]      mem_addr,
  input  logic                                 mem_ack,
  output logic                                 done,
  output logic                                 nostore,
  output logic [10:0]                          vbanks,
  output logic [$clog2(PPM_BASE)+8:0]          real_pages
);
  localparam int VPN_W = 10 + BANK_LOG;
  localparam int PPM_W = $clog2(PPM_BASE) + 7;
  localparam int RPC_W = PPM_W + 2;
  localparam int MSTEP = PAGE_LOG - MUNCH_LOG;

  typedef enum logic [3:0] {
    S_IDLE, S_ONE, S_FL, S_VAC, S_MSEL, S_MAP, S_ZERO,
    S_ADV, S_PFL, S_PWR, S_WAIT, S_DONE
  } st_t;

  st_t st, ret;
  logic                 warm_q, prot_q;
  logic [3:0]           mask_q;
  logic [10:0]          vb_q;
  logic [PPM_W-1:0]     ppm_q, pc;
  logic [BASE_W-1:0]    base_q;
  logic [RPC_W-1:0]     total_q, rp;
  logic [VPN_W-1:0]     vp, vlast, vstart, pvp, vnext;
  logic [VPN_W:0]       vsize;
  logic [10:0]          bsel;
  logic [1:0]           mi;
  logic [PAGE_LOG-1:0]  wc, off;
  logic [MUNCH_LOG-1:0] mc;
  logic [RPN_W-1:0]     prot_rp;

  wire [10:0]      vb_in  = map_large ? 11'd1024 : (map_medium ? 11'd256 : 11'd64);
  wire [PPM_W-1:0] ppm_in = PPM_W'(PPM_BASE) << {chip_code, 1'b0};
  wire [RPC_W-1:0] tot_in = RPC_W'($countones(mod_present)) * RPC_W'(ppm_in);

  assign vsize  = (VPN_W+1)'(vb_q) << BANK_LOG;
  assign vlast  = VPN_W'(vsize - (VPN_W+1)'(1));
  assign bsel   = 11'(base_q) & (vb_q - 11'd1);
  assign vstart = VPN_W'(bsel) << BANK_LOG;
  assign pvp    = vstart | VPN_W'((1 << BANK_LOG) - 1);
  assign vnext  = (vp == vlast) ? '0 : vp + VPN_W'(1);
  wire   st_end = (st == S_MSEL || st == S_ADV) && mi == 2'd3;
  wire   mod_last = (pc == ppm_q - PPM_W'(1));

  assign map_we    = (st == S_ONE || st == S_VAC || st == S_MAP || st == S_PWR) && !map_busy;
  assign map_vpage = (st == S_PWR) ? pvp : vp;
  always_comb begin
    case (st)
      S_ONE:   map_entry = {2'b00, RPN_W'(vp)};
      S_VAC:   map_entry = {2'b11, {RPN_W{1'b0}}};
      S_MAP:   map_entry = {2'b00, RPN_W'(rp)};
      S_PWR:   map_entry = {2'b01, prot_rp};
      default: map_entry = '0;
    endcase
  end

  assign mem_req  = (st == S_FL || st == S_ZERO || st == S_PFL);
  assign mem_zero = (st == S_ZERO);
  assign off      = (st == S_ZERO) ? wc : (PAGE_LOG'(mc) << MSTEP);
  assign mem_addr = {(st == S_PFL) ? pvp : vp, off};

  assign vbanks     = vb_q;
  assign real_pages = total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  ret <= S_IDLE;
      warm_q <= 1'b0; prot_q <= 1'b0; mask_q <= '0; vb_q <= '0;
      ppm_q <= '0; base_q <= '0; total_q <= '0;
      vp <= '0; rp <= '0; mi <= '0; pc <= '0; wc <= '0; mc <= '0;
      prot_rp <= '0; done <= 1'b0; nostore <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          warm_q <= warm; prot_q <= protect_top; mask_q <= mod_present;
          vb_q <= vb_in; ppm_q <= ppm_in; base_q <= base_bank; total_q <= tot_in;
          vp <= '0; mc <= '0; prot_rp <= '0;
          nostore <= (mod_present == 4'd0);
          if (mod_present != 4'd0) st <= warm ? S_FL : S_ONE;
        end
        S_ONE: if (map_we) begin
          ret <= (vp == vlast) ? S_FL : S_ONE;
          vp  <= vnext;
          st  <= S_WAIT;
        end
        S_FL: if (mem_ack) begin
          mc <= mc + MUNCH_LOG'(1);
          if (&mc) st <= S_VAC;
        end
        S_VAC: if (map_we) begin
          st <= S_WAIT;
          if (vp == vlast) begin
            ret <= S_MSEL; vp <= vstart; rp <= '0; mi <= '0;
          end else begin
            ret <= S_FL; vp <= vnext;
          end
        end
        S_MSEL: begin
          pc <= '0;
          if (mask_q[mi]) st <= S_MAP;
          else begin
            rp <= rp + RPC_W'(ppm_q);
            if (st_end) st <= prot_q ? S_PFL : S_DONE;
            else mi <= mi + 2'd1;
          end
        end
        S_MAP: if (map_we) begin
          if (vp == pvp) prot_rp <= RPN_W'(rp);
          wc  <= '0;
          ret <= warm_q ? S_ADV : S_ZERO;
          st  <= S_WAIT;
        end
        S_ZERO: if (mem_ack) begin
          wc <= wc + PAGE_LOG'(1);
          if (&wc) st <= S_ADV;
        end
        S_ADV: begin
          rp <= rp + RPC_W'(1);
          vp <= vnext;
          if (!mod_last) begin
            pc <= pc + PPM_W'(1); st <= S_MAP;
          end else if (st_end) st <= prot_q ? S_PFL : S_DONE;
          else begin
            mi <= mi + 2'd1; st <= S_MSEL;
          end
        end
        S_PFL: if (mem_ack) begin
          mc <= mc + MUNCH_LOG'(1);
          if (&mc) st <= S_PWR;
        end
        S_PWR: if (map_we) begin
          ret <= S_DONE; st <= S_WAIT;
        end
        S_WAIT: if (!map_busy) st <= ret;
        S_DONE: begin
          done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_write_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> !map_busy);
  p_quiet_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> !map_we && !mem_req);
  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_zero));
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_nostore_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nostore |-> !map_we && !mem_req && !done);
  p_total_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(real_pages));
endmodule

// File: tb/test_map_init_seq.sv
`timescale 1ns/1ps
module test_map_init_seq;
  localparam int PL = 3, BL = 1, ML = 1, PB = 4;
  localparam int VW = 10 + BL, AW = VW + PL, RW = $clog2(PB) + 9;

  logic clk = 0, rst_n = 0, start = 0, warm = 0;
  logic [3:0] mod_present = 0;
  logic [1:0] chip_code = 0;
  logic map_large = 0, map_medium = 0, protect_top = 0;
  logic [11:0] base_bank = 0;
  logic map_busy = 0, mem_ack = 0;
  logic map_we, mem_req, mem_zero, done, nostore;
  logic [VW-1:0] map_vpage;
  logic [17:0] map_entry;
  logic [AW-1:0] mem_addr;
  logic [10:0] vbanks;
  logic [RW-1:0] real_pages;

  map_init_seq #(.PAGE_LOG(PL), .BANK_LOG(BL), .MUNCH_LOG(ML), .PPM_BASE(PB),
                 .RPN_W(16), .BASE_W(12)) i_map_init_seq (.*);

  always #2.5 clk = ~clk;

  typedef struct { int kind; int addr; int data; int tag; } item_t;
  item_t expq[$];
  int compared = 0, mismatched = 0, done_cnt = 0, blen = 1, bcnt = 0;
  int exp_real = 0;
  bit pend = 0, run_on = 0, real_bad = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int k, int a, int d, int t);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.tag = t;
    expq.push_back(it);
  endtask

  // monitor: pops the scoreboard as the design produces operations
  task automatic observe(int k, int a, int d);
    item_t e;
    if (expq.size() == 0) begin
      compared++; mismatched++;
      $display("FAIL R8 unexpected op actual kind=%0d addr=%0d expected none", k, a);
      return;
    end
    e = expq.pop_front();
    compared++;
    if (e.kind != k || e.addr != a || e.data != d) begin
      mismatched++;
      $display("FAIL R%0d actual kind=%0d addr=%0d data=%0h expected kind=%0d addr=%0d data=%0h",
               e.tag, k, a, d, e.kind, e.addr, e.data);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (map_we) begin
      if (map_busy) chk(0, "R10 write under busy", 1, 0);
      observe(0, int'(map_vpage), int'(map_entry));
      pend = 1;
    end else if (pend) begin
      pend = 0;
      if (blen > 0) begin map_busy = 1; bcnt = blen; end
    end else if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) map_busy = 0;
    end
    if (mem_req && !mem_ack) begin
      if (map_busy) chk(0, "R10 request during busy", 1, 0);
      observe(mem_zero ? 2 : 1, int'(mem_addr), 0);
      mem_ack = 1;
    end else mem_ack = 0;
    if (done) done_cnt++;
    if (run_on && int'(real_pages) != exp_real) real_bad = 1;
  end

  // driver: builds the expected operation list from the requirements
  task automatic gen(bit cold, logic [3:0] mask, int chip, bit lg, bit md, int base, bit prot);
    int vb, vsz, ppm, v, vs, pv, rp, prp;
    vb  = lg ? 1024 : (md ? 256 : 64);             // R1
    vsz = vb * (1 << BL);
    ppm = PB << (2 * chip);                          // R2
    if (cold) for (int i = 0; i < vsz; i++) push(0, i, i & 16'hFFFF, 3);  // R3
    for (int i = 0; i < vsz; i++) begin             // R4
      for (int m = 0; m < (1 << ML); m++) push(1, i * (1 << PL) + m * (1 << (PL - ML)), 0, 4);
      push(0, i, 18'h30000, 4);
    end
    vs = (base & (vb - 1)) * (1 << BL);             // R6
    pv = vs + (1 << BL) - 1;
    v = vs; rp = 0; prp = 0;
    for (int mi = 0; mi < 4; mi++) begin            // R5
      if (mask[mi]) begin
        for (int p = 0; p < ppm; p++) begin
          push(0, v, rp & 16'hFFFF, (v < vs) ? 6 : 5);
          if (v == pv) prp = rp & 16'hFFFF;
          if (cold) for (int w = 0; w < (1 << PL); w++) push(2, v * (1 << PL) + w, 0, 7);  // R7
          rp++;
          v = (v + 1) % vsz;
        end
      end else rp += ppm;
    end
    if (prot) begin                                  // R9
      for (int m = 0; m < (1 << ML); m++) push(1, pv * (1 << PL) + m * (1 << (PL - ML)), 0, 9);
      push(0, pv, 18'h10000 | prp, 9);
    end
  endtask

  task automatic run_case(bit cold, logic [3:0] mask, int chip, bit lg, bit md, int base,
                          bit prot, int bl);
    int waitc, vb;
    expq.delete();
    gen(cold, mask, chip, lg, md, base, prot);
    vb = lg ? 1024 : (md ? 256 : 64);
    exp_real = $countones(mask) * (PB << (2 * chip));
    @(negedge clk);
    blen = bl; done_cnt = 0; real_bad = 0;
    warm = !cold; mod_present = mask; chip_code = 2'(chip);
    map_large = lg; map_medium = md; base_bank = 12'(base); protect_top = prot;
    start = 1;
    @(negedge clk);
    start = 0; run_on = 1;
    waitc = 0;
    while (done_cnt == 0 && waitc < 60000) begin @(negedge clk); waitc++; end
    repeat (4) @(negedge clk);
    run_on = 0;
    chk(done_cnt == 1, "R12 done pulses", done_cnt, 1);
    chk(expq.size() == 0, "R5 operations left unissued", expq.size(), 0);
    chk(int'(vbanks) == vb, "R1 vbanks", int'(vbanks), vb);
    chk(int'(real_pages) == exp_real, "R2 real_pages", int'(real_pages), exp_real);
    chk(!real_bad, "R2 real_pages steady", real_bad, 0);
    chk(nostore == 0, "R8 nostore clear", nostore, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0, "R12 reset done", done, 0);
    chk(nostore == 0, "R8 reset nostore", nostore, 0);
    chk(map_we == 0 && mem_req == 0, "R10 reset quiet", map_we | mem_req, 0);
    rst_n = 1;
    // cold, scattered modules, small map, no protect
    run_case(1, 4'b1011, 0, 0, 0, 0, 0, 1);
    // warm, medium map, base 5, protect, longer busy
    run_case(0, 4'b0110, 1, 0, 1, 5, 1, 3);
    // cold, base beyond size masked, wraps past the top (R6)
    run_case(1, 4'b1000, 2, 0, 0, 127, 1, 2);
    // no storage (R8)
    @(negedge clk);
    expq.delete(); done_cnt = 0;
    mod_present = 0; warm = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    chk(nostore == 1, "R8 nostore set", nostore, 1);
    chk(done_cnt == 0, "R8 no done", done_cnt, 0);
    // large indicator wins over medium, warm, wrap with protect, zero-length busy
    run_case(0, 4'b0001, 0, 1, 1, 1023, 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule